// File: doc/BRIEF.md
# Indexed Clock Register File and Interrupt Controller

This block is the host-facing side of a real-time clock. The host reaches a 128-byte register space through two locations. A write to the even location picks a byte index. An access to the odd location reads or writes the byte at that index. The block keeps four control and status bytes:

- a rate and divider byte, which also carries the update-in-progress flag;
- a mode byte with the interrupt enables, the data format and the hold (SET) bit;
- a flag byte that clears when it is read;
- a fixed valid-RAM byte.

All other indices are plain storage.

A separate time counter supplies the seven time fields, a start-of-update strobe and an end-of-update strobe. A separate rate generator supplies a periodic tick. When an update ends, the block does three things. It copies the time fields into their slots, unless the hold bit is set. It checks the seconds, minutes and hours alarm bytes against the incoming fields. It raises the update-ended flag.

One level-sensitive interrupt output reports every enabled event. It stays high until the host reads the flag byte. The rate byte and the mode byte are also driven out, so the rate generator and the time counter can use them.

Top module: `rtc_index_hub`

## Requirements
- R1: A host write with `acc_odd`=0 stores the low 7 bits of `acc_wdata` as the current index. While `acc_odd`=0, `acc_rdata` reads 0xFF.
- R2: After reset the four control bytes read as follows: index 10 reads 0x26, index 11 reads 0x02, index 12 reads 0x00 and index 13 reads 0x80. After reset `irq_o` and `sqw_o` are low.
- R3: Bit 7 of index 10 is the update-in-progress flag. A host write to index 10 stores bits 6..0 and leaves bit 7 at its previous value.
- R4: Host writes to index 12 and to index 13 change neither register. Index 13 always reads 0x80, and a pending interrupt stays pending after such a write.
- R5: An odd-location read of index 12 returns the current flags in the same cycle. On the next clock edge it clears all flags to 0x00 and drops `irq_o`.
- R6: A write to index 11 with bit 7 (hold) set does two things. It clears the update-in-progress flag, and bit 4 (update-ended enable) is stored as 0.
- R7: The mode byte bits used here are bit 6, periodic enable, and bit 3, square-wave enable. With bit 6 set, a `rate_tick` ORs 0xC0 into the flags and raises `irq_o`. With bit 3 set, a `rate_tick` gives a one-cycle pulse on `sqw_o` on the next clock edge. With both bits clear, a tick changes nothing.
- R8: The alarm bytes sit at indices 1 (seconds), 3 (minutes) and 5 (hours). An alarm byte with bits 7:6 = 2'b11 matches any value. If bit 5 of the mode byte is set and all three bytes match the incoming fields when `upd_done` is pulsed, the block ORs 0xA0 into the flags and raises `irq_o`.
- R9: `upd_begin` sets the update-in-progress flag unless the hold bit is set. `upd_done` always sets flag bit 4 and clears the update-in-progress flag. It sets flag bit 7 and raises `irq_o` only when bit 4 of the mode byte is set.
- R10: On `upd_done` with the hold bit clear, the time field bytes of `tfld_in` load into the slots below. All other indices below 10 and from 14 up hold what the host last wrote.
  - Byte 0 (bits 7:0) loads into index 0.
  - Bytes 1 and 2 load into indices 2 and 4.
  - Bytes 3 to 6 load into indices 6 to 9.
- R11: `irq_o` is a level. Once raised, it stays high until index 12 is read or reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_odd | input | 1 | Location select: 0 = index, 1 = data |
| acc_wdata | input | 8 | Host write data |
| acc_rdata | output | 8 | Host read data, valid in the strobe cycle |
| tfld_in | input | 56 | Time fields from the counter: sec, min, hour, wday, mday, month, year (byte 0 = sec) |
| upd_begin | input | 1 | One-cycle pulse: time update starts |
| upd_done | input | 1 | One-cycle pulse: time update ends |
| rate_tick | input | 1 | One-cycle periodic tick from the rate generator |
| irq_o | output | 1 | Interrupt level |
| sqw_o | output | 1 | Square-wave pulse |
| ctl_a | output | 8 | Current rate/divider byte |
| ctl_b | output | 8 | Current mode byte |

## Verification
A wrong bit in the flag or mode registers is visible at the ports in two ways. It shows on `irq_o` one clock edge after the event that should or should not have raised it. It also shows in the `acc_rdata` value of the next odd-location read of the affected index. A lost or stuck update-in-progress flag is visible in bit 7 of index 10 on the first read after the begin or end strobe. A missed copy of the time fields, or a missed hold, shows on the first read of a time slot after `upd_done`. The bench reads each of these back within a few cycles of the stimulus that could have disturbed them.

// File: rtl/rtc_hub_pkg.sv
package rtc_hub_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] rbyte_t;

  // control byte indices
  localparam int IX_A = 10;
  localparam int IX_B = 11;
  localparam int IX_C = 12;
  localparam int IX_D = 13;

  // alarm byte indices
  localparam int IX_ALM_S = 1;
  localparam int IX_ALM_M = 3;
  localparam int IX_ALM_H = 5;

  // mode byte bit positions
  localparam int MB_HOLD = 7;
  localparam int MB_PIE  = 6;
  localparam int MB_AIE  = 5;
  localparam int MB_UIE  = 4;
  localparam int MB_SQW  = 3;

  localparam rbyte_t RST_A = 8'h26;
  localparam rbyte_t RST_B = 8'h02;
  localparam rbyte_t RST_D = 8'h80;

  localparam rbyte_t FLG_PER = 8'hC0;
  localparam rbyte_t FLG_ALM = 8'hA0;
  localparam rbyte_t FLG_UPD = 8'h10;
  localparam rbyte_t FLG_ANY = 8'h80;

  // returns the time-field number stored in a slot, or -1 for plain storage
  function automatic int field_of_slot(input int slot);
    case (slot)
      0: return 0;
      2: return 1;
      4: return 2;
      6: return 3;
      7: return 4;
      8: return 5;
      9: return 6;
      default: return -1;
    endcase
  endfunction

  // alarm byte with both top bits set accepts any value
  function automatic logic alarm_field_hit(input rbyte_t alm, input rbyte_t cur);
    return (alm[7:6] == 2'b11) || (alm == cur);
  endfunction
endpackage

// File: rtl/hub_index_port.sv
module hub_index_port #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_we,
  input  logic             acc_odd,
  input  logic [IDX_W-1:0] idx_in,
  output logic [IDX_W-1:0] idx_q,
  output logic             dat_wr,
  output logic             dat_rd
);
  logic idx_wr;

  assign idx_wr = acc_en && acc_we && !acc_odd;
  assign dat_wr = acc_en && acc_we && acc_odd;
  assign dat_rd = acc_en && !acc_we && acc_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_wr) idx_q <= idx_in;
  end

  AST_INDEX_TAKES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q == $past(idx_in)); // R1
  AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(idx_q)); // R1
endmodule

// File: rtl/hub_byte_store.sv
module hub_byte_store
  import rtc_hub_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int NFLD  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  rbyte_t                 wr_data,
  input  logic                   load_en,
  input  logic [NFLD*BYTE_W-1:0] fld_in,
  input  logic [IDX_W-1:0]       rd_idx,
  output rbyte_t                 rd_data,
  output logic [3*BYTE_W-1:0]    alm_bytes
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH*BYTE_W-1:0] flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam int FK = field_of_slot(i);
    rbyte_t q;
    if (FK >= 0 && FK < NFLD) begin : g_time
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en && wr_idx == IDX_W'(i)) q <= wr_data;
        else if (load_en) q <= fld_in[FK*BYTE_W +: BYTE_W];
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en && wr_idx == IDX_W'(i)) q <= wr_data;
      end
    end
    assign flat[i*BYTE_W +: BYTE_W] = q;
  end

  assign rd_data   = flat[rd_idx*BYTE_W +: BYTE_W];
  assign alm_bytes = {flat[IX_ALM_H*BYTE_W +: BYTE_W],
                      flat[IX_ALM_M*BYTE_W +: BYTE_W],
                      flat[IX_ALM_S*BYTE_W +: BYTE_W]};

  AST_SEC_SLOT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !wr_en) |=> flat[BYTE_W-1:0] == $past(fld_in[BYTE_W-1:0])); // R10
  AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !wr_en) |=> $stable(flat)); // R10
endmodule

// File: rtl/hub_alarm_match.sv
module hub_alarm_match
  import rtc_hub_pkg::*;
#(
  parameter int NALM = 3
) (
  input  logic [NALM*BYTE_W-1:0] alm_bytes,
  input  logic [NALM*BYTE_W-1:0] cur_fields,
  output logic                   hit
);
  logic [NALM-1:0] field_ok;

  for (genvar k = 0; k < NALM; k++) begin : g_fld
    assign field_ok[k] = alarm_field_hit(alm_bytes[k*BYTE_W +: BYTE_W],
                                         cur_fields[k*BYTE_W +: BYTE_W]);
  end

  assign hit = &field_ok;
endmodule

// File: rtl/hub_ctrl_regs.sv
module hub_ctrl_regs
  import rtc_hub_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  rbyte_t           wdata,
  input  logic             upd_begin,
  input  logic             upd_done,
  input  logic             rate_tick,
  input  logic             alarm_hit,
  output rbyte_t           reg_a,
  output rbyte_t           reg_b,
  output rbyte_t           reg_c,
  output rbyte_t           reg_d,
  output logic             irq_o,
  output logic             sqw_o
);
  rbyte_t a_q, b_q, c_q, c_set;
  logic   irq_q, sqw_q;

  // named internal events
  logic wr_a, wr_b, wr_cd, rd_c, hold_wr, uip_raise;
  logic per_ev, alm_ev, uie_ev, irq_raise;

  assign wr_a      = wr_en && idx == IDX_W'(IX_A);
  assign wr_b      = wr_en && idx == IDX_W'(IX_B);
  assign wr_cd     = wr_en && (idx == IDX_W'(IX_C) || idx == IDX_W'(IX_D));
  assign rd_c      = rd_en && idx == IDX_W'(IX_C);
  assign hold_wr   = wr_b && wdata[MB_HOLD];
  assign uip_raise = upd_begin && !b_q[MB_HOLD];
  assign per_ev    = rate_tick && b_q[MB_PIE];
  assign alm_ev    = upd_done && b_q[MB_AIE] && alarm_hit;
  assign uie_ev    = upd_done && b_q[MB_UIE];
  assign irq_raise = per_ev || alm_ev || uie_ev;

  always_comb begin
    c_set = '0;
    if (per_ev)   c_set = c_set | FLG_PER;
    if (alm_ev)   c_set = c_set | FLG_ALM;
    if (upd_done) c_set = c_set | FLG_UPD;
    if (uie_ev)   c_set = c_set | FLG_ANY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= RST_A;
    end else begin
      if (wr_a) a_q[6:0] <= wdata[6:0];
      if (upd_done || hold_wr) a_q[7] <= 1'b0;
      else if (uip_raise)      a_q[7] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_q <= RST_B;
    else if (wr_b) begin
      if (wdata[MB_HOLD]) b_q <= wdata & ~(rbyte_t'(1) << MB_UIE);
      else                b_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q   <= '0;
      irq_q <= 1'b0;
      sqw_q <= 1'b0;
    end else begin
      c_q   <= (rd_c ? '0 : c_q) | c_set;
      irq_q <= (irq_q && !rd_c) || irq_raise;
      sqw_q <= rate_tick && b_q[MB_SQW];
    end
  end

  assign reg_a = a_q;
  assign reg_b = b_q;
  assign reg_c = c_q;
  assign reg_d = RST_D;
  assign irq_o = irq_q;
  assign sqw_o = sqw_q;

  AST_UIP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !upd_begin && !upd_done) |=> a_q[7] == $past(a_q[7])); // R3
  AST_FLAGS_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cd && !rate_tick && !upd_done) |=> $stable(c_q) && $stable(irq_q)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !rate_tick && !upd_done) |=> (c_q == '0) && !irq_q); // R5
  AST_HOLD_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> !b_q[MB_UIE] && !a_q[7]); // R6
  AST_PERIODIC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    per_ev |=> c_q[6] && c_q[7] && irq_q); // R7
  AST_SQW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_tick && b_q[MB_SQW]) |=> sqw_o); // R7
  AST_ALARM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    alm_ev |=> c_q[5] && c_q[7] && irq_q); // R8
  AST_UPDATE_END: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> c_q[4] && !a_q[7]); // R9
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !rd_c) |=> irq_q); // R11
endmodule

// File: rtl/rtc_index_hub.sv
module rtc_index_hub
  import rtc_hub_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int NFLD  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_en,
  input  logic                   acc_we,
  input  logic                   acc_odd,
  input  logic [BYTE_W-1:0]      acc_wdata,
  output logic [BYTE_W-1:0]      acc_rdata,
  input  logic [NFLD*BYTE_W-1:0] tfld_in,
  input  logic                   upd_begin,
  input  logic                   upd_done,
  input  logic                   rate_tick,
  output logic                   irq_o,
  output logic                   sqw_o,
  output logic [BYTE_W-1:0]      ctl_a,
  output logic [BYTE_W-1:0]      ctl_b
);
  localparam int NALM = 3;

  logic [IDX_W-1:0] idx_q;
  logic             dat_wr, dat_rd, ctl_sel, load_en, alarm_hit;
  rbyte_t           store_rd, reg_a, reg_b, reg_c, reg_d, ctl_rd;
  logic [NALM*BYTE_W-1:0] alm_bytes;

  hub_index_port #(.IDX_W(IDX_W)) u_port (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_odd(acc_odd), .idx_in(acc_wdata[IDX_W-1:0]), .idx_q(idx_q),
    .dat_wr(dat_wr), .dat_rd(dat_rd));

  assign ctl_sel = idx_q >= IDX_W'(IX_A) && idx_q <= IDX_W'(IX_D);
  assign load_en = upd_done && !reg_b[MB_HOLD];

  hub_byte_store #(.IDX_W(IDX_W), .NFLD(NFLD)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(dat_wr && !ctl_sel), .wr_idx(idx_q),
    .wr_data(acc_wdata), .load_en(load_en), .fld_in(tfld_in),
    .rd_idx(idx_q), .rd_data(store_rd), .alm_bytes(alm_bytes));

  hub_alarm_match #(.NALM(NALM)) u_alarm (
    .alm_bytes(alm_bytes), .cur_fields(tfld_in[NALM*BYTE_W-1:0]),
    .hit(alarm_hit));

  hub_ctrl_regs #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(dat_wr), .rd_en(dat_rd), .idx(idx_q),
    .wdata(acc_wdata), .upd_begin(upd_begin), .upd_done(upd_done),
    .rate_tick(rate_tick), .alarm_hit(alarm_hit), .reg_a(reg_a),
    .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d), .irq_o(irq_o),
    .sqw_o(sqw_o));

  always_comb begin
    case (idx_q)
      IDX_W'(IX_A): ctl_rd = reg_a;
      IDX_W'(IX_B): ctl_rd = reg_b;
      IDX_W'(IX_C): ctl_rd = reg_c;
      default:      ctl_rd = reg_d;
    endcase
  end

  assign acc_rdata = !acc_odd ? 8'hFF : (ctl_sel ? ctl_rd : store_rd);
  assign ctl_a = reg_a;
  assign ctl_b = reg_b;

  AST_EVEN_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && !acc_odd) |-> acc_rdata == 8'hFF); // R1
  AST_VALID_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_odd && idx_q == IDX_W'(IX_D)) |-> acc_rdata == RST_D); // R4
endmodule

// File: tb/rtc_index_hub_test.sv
`timescale 1ns/1ps
module rtc_index_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_we = 1'b0, acc_odd = 1'b0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  acc_rdata;
  logic [55:0] tfld_in = '0;
  logic        upd_begin = 1'b0, upd_done = 1'b0, rate_tick = 1'b0;
  logic        irq_o, sqw_o;
  logic [7:0]  ctl_a, ctl_b;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rtc_index_hub uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_odd(acc_odd), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .tfld_in(tfld_in), .upd_begin(upd_begin), .upd_done(upd_done),
    .rate_tick(rate_tick), .irq_o(irq_o), .sqw_o(sqw_o),
    .ctl_a(ctl_a), .ctl_b(ctl_b));

  // {index byte written, data written, expected readback}
  localparam logic [23:0] VEC [8] = '{
    24'h0E_5A_5A,   // plain slot
    24'hFF_C3_C3,   // index 0x7F, top bit of index byte dropped
    24'h01_30_30,   // alarm seconds slot
    24'h0A_A5_25,   // rate byte, bit 7 stays 0
    24'h0C_FF_00,   // flag byte is read-only
    24'h0D_00_80,   // valid-RAM byte is read-only
    24'h0B_06_06,   // mode byte
    24'h09_99_99    // year slot
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr_idx(input logic [7:0] b);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_odd = 1'b0; acc_wdata = b;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] b);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_odd = 1'b1; acc_wdata = b;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd_dat(output logic [7:0] v);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_odd = 1'b1;
    #1 v = acc_rdata;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    wr_idx(i); wr_dat(d);
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
    wr_idx(i); rd_dat(v);
  endtask

  task automatic pulse_begin();
    @(negedge clk); upd_begin = 1'b1; @(negedge clk); upd_begin = 1'b0;
  endtask
  task automatic pulse_done();
    @(negedge clk); upd_done = 1'b1; @(negedge clk); upd_done = 1'b0;
  endtask
  task automatic pulse_tick();
    @(negedge clk); rate_tick = 1'b1; @(negedge clk); rate_tick = 1'b0;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R2 irq after reset", {7'd0, irq_o}, 8'h00);
    chk("R2 sqw after reset", {7'd0, sqw_o}, 8'h00);
    chk("R2 ctl_a after reset", ctl_a, 8'h26);
    rd_reg(8'h0A, v); chk("R2 reg A", v, 8'h26);
    rd_reg(8'h0B, v); chk("R2 reg B", v, 8'h02);
    rd_reg(8'h0C, v); chk("R2 reg C", v, 8'h00);
    rd_reg(8'h0D, v); chk("R2 reg D", v, 8'h80);

    // even location
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_odd = 1'b0;
    #1 chk("R1 even read", acc_rdata, 8'hFF);
    @(negedge clk); acc_en = 1'b0;
    rd_reg(8'h8B, v); chk("R1 index low 7 bits", v, 8'h02);

    // vector table
    for (int n = 0; n < 8; n++) begin
      wr_reg(VEC[n][23:16], VEC[n][15:8]);
      rd_reg(VEC[n][23:16], v);
      chk($sformatf("table entry %0d (R1,R3,R4,R10)", n), v, VEC[n][7:0]);
    end
    wr_reg(8'h0A, 8'h26);
    wr_reg(8'h0B, 8'h02);

    // update-in-progress kept across a rate byte write
    pulse_begin();
    rd_reg(8'h0A, v); chk("R9 begin sets UIP", v, 8'hA6);
    wr_dat(8'h20);
    rd_dat(v); chk("R3 UIP kept on write", v, 8'hA0);
    tfld_in = {8'h24, 8'h02, 8'h28, 8'h03, 8'h09, 8'h42, 8'h15};
    pulse_done();
    chk("R9 no irq without enable", {7'd0, irq_o}, 8'h00);
    rd_reg(8'h0A, v); chk("R9 end clears UIP", v, 8'h20);
    rd_reg(8'h0C, v); chk("R9 update flag only", v, 8'h10);
    rd_dat(v); chk("R5 flags cleared", v, 8'h00);
    rd_reg(8'h00, v); chk("R10 sec slot", v, 8'h15);
    rd_reg(8'h04, v); chk("R10 hour slot", v, 8'h09);
    rd_reg(8'h09, v); chk("R10 year slot", v, 8'h24);

    // hold mode
    wr_reg(8'h0A, 8'h26);
    pulse_begin();
    wr_reg(8'h0B, 8'h92);
    rd_dat(v); chk("R6 UIE masked", v, 8'h82);
    rd_reg(8'h0A, v); chk("R6 UIP cleared", v, 8'h26);
    tfld_in[7:0] = 8'h55;
    pulse_begin();
    rd_reg(8'h0A, v); chk("R9 begin ignored in hold", v, 8'h26);
    pulse_done();
    rd_reg(8'h00, v); chk("R10 no load in hold", v, 8'h15);
    rd_reg(8'h0C, v); chk("R9 update flag in hold", v, 8'h10);

    // update-ended interrupt, level, read-only flags
    wr_reg(8'h0B, 8'h12);
    pulse_done();
    chk("R9 irq on update end", {7'd0, irq_o}, 8'h01);
    repeat (4) @(negedge clk);
    chk("R11 irq held", {7'd0, irq_o}, 8'h01);
    wr_reg(8'h0C, 8'h00);
    wr_reg(8'h0D, 8'h55);
    rd_dat(v); chk("R4 reg D fixed", v, 8'h80);
    chk("R4 irq survives writes", {7'd0, irq_o}, 8'h01);
    rd_reg(8'h0C, v); chk("R5 flags read", v, 8'h90);
    chk("R5 irq dropped", {7'd0, irq_o}, 8'h00);
    rd_dat(v); chk("R5 flags zero", v, 8'h00);
    rd_reg(8'h00, v); chk("R10 load after hold", v, 8'h55);

    // periodic and square wave
    wr_reg(8'h0B, 8'h42);
    pulse_tick();
    chk("R7 periodic irq", {7'd0, irq_o}, 8'h01);
    rd_reg(8'h0C, v); chk("R7 periodic flags", v, 8'hC0);
    wr_reg(8'h0B, 8'h0A);
    pulse_tick();
    chk("R7 sqw pulse", {7'd0, sqw_o}, 8'h01);
    @(negedge clk);
    chk("R7 sqw one cycle", {7'd0, sqw_o}, 8'h00);
    chk("R7 no irq without enable", {7'd0, irq_o}, 8'h00);
    rd_reg(8'h0C, v); chk("R7 no flags without enable", v, 8'h00);

    // alarm
    wr_reg(8'h01, 8'h30);
    wr_reg(8'h03, 8'hC0);
    wr_reg(8'h05, 8'h12);
    wr_reg(8'h0B, 8'h22);
    tfld_in[23:0] = {8'h12, 8'h45, 8'h30};
    pulse_done();
    chk("R8 alarm irq", {7'd0, irq_o}, 8'h01);
    rd_reg(8'h0C, v); chk("R8 alarm with wildcard", v, 8'hB0);
    tfld_in[23:16] = 8'h13;
    pulse_done();
    chk("R8 no irq on hour miss", {7'd0, irq_o}, 8'h00);
    rd_reg(8'h0C, v); chk("R8 hour miss", v, 8'h10);
    tfld_in[23:16] = 8'h12;
    wr_reg(8'h03, 8'h44);
    pulse_done();
    rd_reg(8'h0C, v); chk("R8 minute miss", v, 8'h10);
    wr_reg(8'h03, 8'h45);
    wr_reg(8'h0B, 8'h02);
    pulse_done();
    chk("R8 no irq when disabled", {7'd0, irq_o}, 8'h00);
    rd_reg(8'h0C, v); chk("R8 match but disabled", v, 8'h10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule